// File: doc/BRIEF.md
# Fast Trigger Source Sequencer

This block produces single-cycle trigger and fast-command strobes for a detector timing module clocked at the 40 MHz bunch rate. A trigger can be made by an internal fixed-rate generator, by an internal pseudo-random generator, or by an external input. The external trigger path enforces a minimum spacing between accepted triggers. Internal periodic generators also make event-counter-reset, bunch-counter-reset, front-end-reset and busy strobes. External command inputs can be routed to the same strobe outputs.

Software configures the block through a narrow register write port. There are two registers. The source-select word turns each generator and each external path on or off. The rate word slows every internal generator down by an integer factor. The register addresses are byte addresses, so register index n sits at address 2n.

All external inputs are treated as asynchronous. They are resynchronised and edge-detected inside the block. Every output is a registered level that is high for exactly one clock per event. No data stream crosses the block edge, so there is no valid/ready handshake. Every pin is a plain control or strobe signal with no back-pressure.

Top module: `trig_seq_top`

## Requirements
- R1: Every strobe output is registered. A single event is high for exactly one clock. An external edge can never produce two adjacent high cycles on its output.
- R2: A write with address 0x0 loads the source-select word. A write with address 0x6 loads the low 4 bits of the rate word. A write to any other address changes nothing.
- R3: With select bit 1 set and bit 4 clear, trig_o pulses every 66 × D clocks. D is the rate word, and a rate word of 0 counts as 1. The first pulse comes 66 × D clocks after the select write takes effect.
- R4: A rate word of 0 gives the same trigger period as a rate word of 1. A rate word of 2 doubles the period.
- R5: With select bits 1 and 4 both set, the fixed-rate trigger is off and random triggering is on. The random generator is a 16-bit right-shifting Galois LFSR with tap mask 0xB400 and seed 0xACE1, and it advances on every clock after reset. trig_o fires when the low min(7 + D, 15) LFSR bits are all zero.
- R6: With select bit 9 set, a rising edge on ext_trig_i is accepted only when at least 3 clocks have passed since the last accepted edge. Edges that arrive sooner are dropped.
- R7: Select bits 2, 3, 5 and 7 enable the internal periodic ecr_o, bcr_o, fer_o and busy_o generators. Their base periods are 2000, 3559, 1500 and 500 clocks, each multiplied by D. A generator's output pulses only while its bit is set.
- R8: Select bits 10, 11, 13 and 14 route rising edges of ext_ecr_i, ext_bcr_i, ext_fer_i and ext_spare_i to ecr_o, bcr_o, fer_o and spare_o. These paths have no hold-off. An edge is dropped while its bit is clear.
- R9: trig_o is the OR of the enabled trigger sources. It is never high unless select bit 1 or bit 9 was set on the previous clock. On an external path, an input rise sampled at a clock edge reaches the output 3 clock edges later.
- R10: While rst_n is low, every output is low, both registers are cleared and the LFSR holds its seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz bunch clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register byte address |
| wr_data | input | 16 | Register write data |
| ext_trig_i | input | 1 | External trigger input, asynchronous |
| ext_ecr_i | input | 1 | External event-counter reset, asynchronous |
| ext_bcr_i | input | 1 | External bunch-counter reset, asynchronous |
| ext_fer_i | input | 1 | External front-end reset, asynchronous |
| ext_spare_i | input | 1 | External spare command, asynchronous |
| trig_o | output | 1 | Trigger strobe |
| ecr_o | output | 1 | Event-counter-reset strobe |
| bcr_o | output | 1 | Bunch-counter-reset strobe |
| fer_o | output | 1 | Front-end-reset strobe |
| spare_o | output | 1 | Spare command strobe |
| busy_o | output | 1 | Internal busy strobe |

## Verification
The assertions check the following on every cycle:
- Accepted external triggers keep their spacing.
- The spare strobe never lasts two cycles.
- Each of trig_o, ecr_o, spare_o and busy_o appears only after its select bits were set.

Exact periods, the halving by the rate word, the random firing pattern, ignored addresses and the three-edge external latency need whole scenarios. The bench shows them by comparing against its cycle reference model and by counting pulses over fixed windows.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;
  // source-select bit positions
  localparam int SEL_INT_TRIG  = 1;
  localparam int SEL_INT_ECR   = 2;
  localparam int SEL_INT_BCR   = 3;
  localparam int SEL_RANDOM    = 4;
  localparam int SEL_INT_FER   = 5;
  localparam int SEL_INT_BUSY  = 7;
  localparam int SEL_EXT_TRIG  = 9;
  localparam int SEL_EXT_ECR   = 10;
  localparam int SEL_EXT_BCR   = 11;
  localparam int SEL_EXT_FER   = 13;
  localparam int SEL_EXT_SPARE = 14;

  // register byte addresses (index n at 2n)
  localparam int REG_SELECT = 0;
  localparam int REG_RATE   = 6;

  // external input lanes
  localparam int LANE_TRIG  = 0;
  localparam int LANE_ECR   = 1;
  localparam int LANE_BCR   = 2;
  localparam int LANE_FER   = 3;
  localparam int LANE_SPARE = 4;
  localparam int NUM_LANES  = 5;

  // internal periodic generators
  localparam int GEN_TRIG = 0;
  localparam int GEN_ECR  = 1;
  localparam int GEN_BCR  = 2;
  localparam int GEN_FER  = 3;
  localparam int GEN_BUSY = 4;
  localparam int NUM_GENS = 5;
endpackage

// File: rtl/trig_seq_regs.sv
module trig_seq_regs import trig_seq_pkg::*; #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int RATE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] sel_q,
  output logic [RATE_W-1:0] rate_eff
);
  logic [RATE_W-1:0] rate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      rate_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(REG_SELECT)) sel_q  <= wr_data;
      if (wr_addr == ADDR_W'(REG_RATE))   rate_q <= wr_data[RATE_W-1:0];
    end
  end

  // a rate word of zero behaves like one
  assign rate_eff = (rate_q == '0) ? RATE_W'(1) : rate_q;
endmodule

// File: rtl/trig_seq_periodic.sv
module trig_seq_periodic #(
  parameter int BASE   = 66,
  parameter int RATE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [RATE_W-1:0] rate,
  output logic              pulse
);
  localparam int MAX_PERIOD = BASE * ((1 << RATE_W) - 1);
  localparam int CNT_W      = $clog2(MAX_PERIOD + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] reload;

  assign reload = CNT_W'(BASE * int'(rate) - 1);
  assign pulse  = en && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!en)          cnt <= reload;
    else if (cnt == '0)    cnt <= reload;
    else                   cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/trig_seq_random.sv
module trig_seq_random #(
  parameter int          W         = 16,
  parameter logic [W-1:0] TAPS     = 16'hB400,
  parameter logic [W-1:0] SEED     = 16'hACE1,
  parameter int          BASE_BITS = 8,
  parameter int          RATE_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [RATE_W-1:0] rate,
  output logic              hit
);
  logic [W-1:0] lfsr;
  logic [W-1:0] mask;
  int           width;

  always_comb begin
    width = BASE_BITS + int'(rate) - 1;
    if (width > W - 1) width = W - 1;
    for (int i = 0; i < W; i++) mask[i] = (i < width);
  end

  assign hit = en && ((lfsr & mask) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr <= SEED;
    else        lfsr <= {1'b0, lfsr[W-1:1]} ^ (lfsr[0] ? TAPS : '0);
  end
endmodule

// File: rtl/trig_seq_sync_edge.sv
module trig_seq_sync_edge #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] rise
);
  logic [N-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise = sync_q & ~prev_q;
endmodule

// File: rtl/trig_seq_top.sv
module trig_seq_top import trig_seq_pkg::*; #(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 16,
  parameter int RATE_W      = 4,
  parameter int TRIG_PERIOD = 66,
  parameter int ECR_PERIOD  = 2000,
  parameter int BCR_PERIOD  = 3559,
  parameter int FER_PERIOD  = 1500,
  parameter int BUSY_PERIOD = 500,
  parameter int RAND_BITS   = 8,
  parameter int EXT_GAP     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ext_trig_i,
  input  logic              ext_ecr_i,
  input  logic              ext_bcr_i,
  input  logic              ext_fer_i,
  input  logic              ext_spare_i,
  output logic              trig_o,
  output logic              ecr_o,
  output logic              bcr_o,
  output logic              fer_o,
  output logic              spare_o,
  output logic              busy_o
);
  localparam int HOLD   = EXT_GAP - 1;
  localparam int HOLD_W = $clog2(HOLD + 1);

  function automatic int gen_period(input int k);
    case (k)
      GEN_TRIG: return TRIG_PERIOD;
      GEN_ECR:  return ECR_PERIOD;
      GEN_BCR:  return BCR_PERIOD;
      GEN_FER:  return FER_PERIOD;
      default:  return BUSY_PERIOD;
    endcase
  endfunction

  logic [DATA_W-1:0]    sel_q;
  logic [RATE_W-1:0]    rate_eff;
  logic [NUM_GENS-1:0]  gen_en, gen_pulse;
  logic [NUM_LANES-1:0] ext_raw, ext_rise;
  logic                 rand_hit;
  logic                 ext_acc;
  logic [HOLD_W-1:0]    hold_q;

  trig_seq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RATE_W(RATE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sel_q(sel_q), .rate_eff(rate_eff)
  );

  assign gen_en[GEN_TRIG] = sel_q[SEL_INT_TRIG] & ~sel_q[SEL_RANDOM];
  assign gen_en[GEN_ECR]  = sel_q[SEL_INT_ECR];
  assign gen_en[GEN_BCR]  = sel_q[SEL_INT_BCR];
  assign gen_en[GEN_FER]  = sel_q[SEL_INT_FER];
  assign gen_en[GEN_BUSY] = sel_q[SEL_INT_BUSY];

  for (genvar g = 0; g < NUM_GENS; g++) begin : g_gen
    trig_seq_periodic #(.BASE(gen_period(g)), .RATE_W(RATE_W)) u_per (
      .clk(clk), .rst_n(rst_n), .en(gen_en[g]), .rate(rate_eff),
      .pulse(gen_pulse[g])
    );
  end

  trig_seq_random #(.BASE_BITS(RAND_BITS), .RATE_W(RATE_W)) u_rand (
    .clk(clk), .rst_n(rst_n),
    .en(sel_q[SEL_INT_TRIG] & sel_q[SEL_RANDOM]),
    .rate(rate_eff), .hit(rand_hit)
  );

  assign ext_raw[LANE_TRIG]  = ext_trig_i;
  assign ext_raw[LANE_ECR]   = ext_ecr_i;
  assign ext_raw[LANE_BCR]   = ext_bcr_i;
  assign ext_raw[LANE_FER]   = ext_fer_i;
  assign ext_raw[LANE_SPARE] = ext_spare_i;

  trig_seq_sync_edge #(.N(NUM_LANES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(ext_raw), .rise(ext_rise)
  );

  // hold-off window for accepted external triggers
  assign ext_acc = sel_q[SEL_EXT_TRIG] && ext_rise[LANE_TRIG] && (hold_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              hold_q <= '0;
    else if (ext_acc)        hold_q <= HOLD_W'(HOLD);
    else if (hold_q != '0)   hold_q <= hold_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_o  <= 1'b0;
      ecr_o   <= 1'b0;
      bcr_o   <= 1'b0;
      fer_o   <= 1'b0;
      spare_o <= 1'b0;
      busy_o  <= 1'b0;
    end else begin
      trig_o  <= gen_pulse[GEN_TRIG] | rand_hit | ext_acc;
      ecr_o   <= gen_pulse[GEN_ECR] | (sel_q[SEL_EXT_ECR] & ext_rise[LANE_ECR]);
      bcr_o   <= gen_pulse[GEN_BCR] | (sel_q[SEL_EXT_BCR] & ext_rise[LANE_BCR]);
      fer_o   <= gen_pulse[GEN_FER] | (sel_q[SEL_EXT_FER] & ext_rise[LANE_FER]);
      spare_o <= sel_q[SEL_EXT_SPARE] & ext_rise[LANE_SPARE];
      busy_o  <= gen_pulse[GEN_BUSY];
    end
  end
endmodule

// File: rtl/trig_seq_chk.sv
module trig_seq_chk import trig_seq_pkg::*; #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] sel_q,
  input logic              ext_acc,
  input logic              trig_o,
  input logic              ecr_o,
  input logic              spare_o,
  input logic              busy_o
);
  AST_EXT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    ext_acc |=> !ext_acc ##1 !ext_acc); // R6

  AST_SPARE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    spare_o |=> !spare_o); // R1

  AST_TRIG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> $past(sel_q[SEL_INT_TRIG] | sel_q[SEL_EXT_TRIG])); // R9

  AST_SPARE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    spare_o |-> $past(sel_q[SEL_EXT_SPARE])); // R8

  AST_BUSY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> $past(sel_q[SEL_INT_BUSY])); // R7

  AST_ECR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    ecr_o |-> $past(sel_q[SEL_INT_ECR] | sel_q[SEL_EXT_ECR])); // R7
endmodule

bind trig_seq_top trig_seq_chk #(.DATA_W(DATA_W)) i_trig_seq_chk (
  .clk(clk), .rst_n(rst_n), .sel_q(sel_q), .ext_acc(ext_acc),
  .trig_o(trig_o), .ecr_o(ecr_o), .spare_o(spare_o), .busy_o(busy_o)
);

// File: tb/test_trig_seq_top.sv
module test_trig_seq_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [4:0]  ext_in = '0;   // 0 trig,1 ecr,2 bcr,3 fer,4 spare
  logic trig_o, ecr_o, bcr_o, fer_o, spare_o, busy_o;

  trig_seq_top i_trig_seq_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ext_trig_i(ext_in[0]), .ext_ecr_i(ext_in[1]), .ext_bcr_i(ext_in[2]),
    .ext_fer_i(ext_in[3]), .ext_spare_i(ext_in[4]),
    .trig_o(trig_o), .ecr_o(ecr_o), .bcr_o(bcr_o), .fer_o(fer_o),
    .spare_o(spare_o), .busy_o(busy_o)
  );

  int checks = 0, errors = 0, cyc = 0;
  string phase = "R10";

  // ---------------- behavioural reference model ----------------
  int base_per[5] = '{66, 2000, 3559, 1500, 500};
  int m_sel, m_rate, m_lfsr, m_hold;
  int m_cnt[5];
  int q1[5], q2[5], q3[5];
  bit [5:0] m_out;  // {busy,spare,fer,bcr,ecr,trig}

  always @(posedge clk) begin
    int d, w;
    bit on[5];
    bit pl[5];
    bit ed[5];
    bit rh, acc;
    if (!rst_n) begin
      m_sel = 0; m_rate = 0; m_lfsr = 'hACE1; m_hold = 0; m_out = '0;
      for (int i = 0; i < 5; i++) begin m_cnt[i] = 0; q1[i] = 0; q2[i] = 0; q3[i] = 0; end
    end else begin
      d = (m_rate == 0) ? 1 : m_rate;
      on[0] = m_sel[1] && !m_sel[4];
      on[1] = m_sel[2]; on[2] = m_sel[3]; on[3] = m_sel[5]; on[4] = m_sel[7];
      for (int i = 0; i < 5; i++) begin
        pl[i] = on[i] && m_cnt[i] == 0;
        if (!on[i] || m_cnt[i] == 0) m_cnt[i] = base_per[i] * d - 1;
        else m_cnt[i] = m_cnt[i] - 1;
        ed[i] = q2[i] && !q3[i];
      end
      w = 7 + d; if (w > 15) w = 15;
      rh = m_sel[1] && m_sel[4] && ((m_lfsr & ((1 << w) - 1)) == 0);
      acc = m_sel[9] && ed[0] && m_hold == 0;
      if (acc) m_hold = 2; else if (m_hold > 0) m_hold = m_hold - 1;
      m_out[0] = pl[0] | rh | acc;
      m_out[1] = pl[1] | (m_sel[10] && ed[1]);
      m_out[2] = pl[2] | (m_sel[11] && ed[2]);
      m_out[3] = pl[3] | (m_sel[13] && ed[3]);
      m_out[4] = m_sel[14] && ed[4];
      m_out[5] = pl[4];
      for (int i = 0; i < 5; i++) begin q3[i] = q2[i]; q2[i] = q1[i]; q1[i] = int'(ext_in[i]); end
      if (m_lfsr & 1) m_lfsr = (m_lfsr >> 1) ^ 'hB400; else m_lfsr = m_lfsr >> 1;
      if (wr_en && wr_addr == 4'h0) m_sel = int'(wr_data);
      if (wr_en && wr_addr == 4'h6) m_rate = int'(wr_data[3:0]);
    end
  end

  // ---------------- comparison and pulse bookkeeping ----------------
  int n_trig, n_ecr, n_bcr, n_fer, n_spare, n_busy;
  int last_trig, min_gap;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    bit [5:0] dut;
    dut = {busy_o, spare_o, fer_o, bcr_o, ecr_o, trig_o};
    check(dut == m_out, phase, int'(dut), int'(m_out));
    if (trig_o) begin
      if (last_trig >= 0 && cyc - last_trig < min_gap) min_gap = cyc - last_trig;
      last_trig = cyc; n_trig++;
    end
    if (ecr_o) n_ecr++;
    if (bcr_o) n_bcr++;
    if (fer_o) n_fer++;
    if (spare_o) n_spare++;
    if (busy_o) n_busy++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic clear_counts();
    n_trig = 0; n_ecr = 0; n_bcr = 0; n_fer = 0; n_spare = 0; n_busy = 0;
    last_trig = -1; min_gap = 1000000;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] v);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int c1, c2, lat;
    clear_counts();
    run(5);
    check({trig_o, ecr_o, bcr_o, fer_o, spare_o, busy_o} == 6'b0, "R10", 1, 0);
    rst_n = 1'b1;
    run(5);

    // R2: writes to other addresses have no effect
    phase = "R2";
    wr(4'h2, 16'hFFFF); wr(4'h4, 16'hFFFF); wr(4'hE, 16'hFFFF);
    clear_counts(); run(300);
    check(n_trig + n_ecr + n_bcr + n_fer + n_busy == 0, "R2", n_trig + n_busy, 0);

    // R3: fixed-rate trigger, base period
    phase = "R3";
    wr(4'h0, 16'h0002); clear_counts(); run(690);
    check(n_trig == 10, "R3", n_trig, 10);
    check(min_gap == 66, "R3 period", min_gap, 66);
    check(n_ecr + n_bcr + n_fer + n_busy == 0, "R3 others", n_ecr + n_busy, 0);

    // R4: rate word 2 halves the rate, 0 behaves like 1
    phase = "R4";
    wr(4'h0, 16'h0000); wr(4'h6, 16'h0002); wr(4'h0, 16'h0002);
    clear_counts(); run(690);
    check(n_trig == 5, "R4", n_trig, 5);
    check(min_gap == 132, "R4 period", min_gap, 132);
    wr(4'h0, 16'h0000); wr(4'h6, 16'h0001); wr(4'h0, 16'h0002);
    clear_counts(); run(690);
    c1 = n_trig;
    wr(4'h0, 16'h0000); wr(4'h6, 16'h0000); wr(4'h0, 16'h0002);
    clear_counts(); run(690);
    check(n_trig == c1, "R4 zero", n_trig, c1);

    // R5: random mode, rate word narrows it further
    phase = "R5";
    wr(4'h0, 16'h0012); clear_counts(); run(20000);
    c1 = n_trig;
    check(c1 > 20 && c1 < 200, "R5 count", c1, 78);
    wr(4'h6, 16'h0002); clear_counts(); run(20000);
    c2 = n_trig;
    check(c2 < c1, "R5 halved", c2, c1 / 2);
    wr(4'h0, 16'h0000); wr(4'h6, 16'h0000);

    // R6: external trigger hold-off
    phase = "R6";
    wr(4'h0, 16'h0200); run(10); clear_counts();
    for (int i = 0; i < 200; i++) begin ext_in[0] = ~ext_in[0]; run(1); end
    ext_in[0] = 1'b0; run(10);
    check(min_gap == 4, "R6 toggle gap", min_gap, 4);
    check(n_trig == 50, "R6 toggle count", n_trig, 50);
    clear_counts();
    for (int i = 0; i < 300; i++) begin ext_in[0] = (i % 3 == 0); run(1); end
    ext_in[0] = 1'b0; run(10);
    check(min_gap == 3, "R6 min gap", min_gap, 3);
    check(n_trig == 100, "R6 count", n_trig, 100);

    // R9: three-edge latency on the external path
    phase = "R9";
    run(10); clear_counts();
    ext_in[0] = 1'b1; lat = 0;
    while (!trig_o && lat < 20) begin run(1); lat++; end
    check(lat == 3, "R9 latency", lat, 3);
    ext_in[0] = 1'b0; run(10);

    // R8: external commands, enabled then disabled
    phase = "R8";
    wr(4'h0, 16'h6C00); run(5); clear_counts();
    ext_in[4:1] = 4'hF; run(3); ext_in[4:1] = 4'h0; run(10);
    check(n_ecr == 1 && n_bcr == 1, "R8 ecr/bcr", n_ecr + n_bcr, 2);
    check(n_fer == 1 && n_spare == 1, "R8 fer/spare", n_fer + n_spare, 2);
    check(n_trig == 0, "R8 no trig", n_trig, 0);
    wr(4'h0, 16'h0000); clear_counts();
    ext_in[4:1] = 4'hF; run(3); ext_in[4:1] = 4'h0; run(10);
    check(n_ecr + n_bcr + n_fer + n_spare == 0, "R8 disabled", n_ecr + n_spare, 0);

    // R7: internal command generators
    phase = "R7";
    wr(4'h0, 16'h00AC); clear_counts(); run(7990);
    check(n_ecr == 3, "R7 ecr", n_ecr, 3);
    check(n_bcr == 2, "R7 bcr", n_bcr, 2);
    check(n_fer == 5, "R7 fer", n_fer, 5);
    check(n_busy == 15, "R7 busy", n_busy, 15);
    check(n_trig == 0, "R7 no trig", n_trig, 0);
    wr(4'h0, 16'h0000); wr(4'h6, 16'h0002); wr(4'h0, 16'h0008);
    clear_counts(); run(7990);
    check(n_bcr == 1, "R7 bcr scaled", n_bcr, 1);

    // R1: single-cycle strobes (model comparison every clock covers width)
    phase = "R1";
    check(min_gap > 1, "R1 width", min_gap, 2);

    wr(4'h0, 16'h0000); run(5);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule